// File: doc/BRIEF.md
# Cartridge Program/Pattern Bank Register Decoder

This block holds the bank-control registers of a cartridge memory mapper. It watches CPU writes in the upper half of the address space, stores the written values in a small set of bank registers, and turns them into a bank number for each of four 8 KB program slots and eight 1 KB pattern slots. It also produces the enable flag that gates the work RAM window at 0x6000–0x7FFF. Logic elsewhere uses that flag to pick between RAM data and the open-bus value.

Two board wirings exist. They differ only in how the two low CPU address lines reach the register decoder, and a strap input picks between them. A control register sets how the eight pattern slots share the eight pattern registers. A split flag makes each paired 2 KB region use the even and odd halves of one 1 KB-granular bank. All slot outputs and the RAM enable are registered.

Top module: `cart_bank_decoder`

## Requirements
- R1: A write acts only when `cpu_wr` is 1 and address bit 15 is 1. Only address bits 15:12 and 1:0 take part in decode. Writes to groups 0x9, 0xA and 0xF, to group 0xB with low bits other than 3, and to any address below 0x8000 change no output.
- R2: With `variant_sel` = 1, address bits 1 and 0 are exchanged before decode. With `variant_sel` = 0 they are used as they are. For example, a write to 0xD001 loads pattern register 2 when the strap is set, and register 1 when it is clear.
- R3: A write to group 0x8 stores n = data[3:0]. Program slot 0 (bits 7:0 of `prg_bank_o`) then shows 2n and slot 1 (bits 15:8) shows 2n+1.
- R4: A write to group 0xC stores data[4:0] as the bank of program slot 2 (bits 23:16). Slot 3 (bits 31:24) always shows PRG_BANKS-1.
- R5: A write to group 0xD with decoded low bits i loads all 8 data bits into pattern register i. A write to group 0xE loads pattern register 4+i.
- R6: A write to decoded address 0xB003 loads the control fields: mode = data[1:0], split = data[5] and work-RAM enable = data[7]. `wram_en_o` follows data[7]. Bits 2, 3, 4 and 6 have no effect.
- R7: In mode 0, pattern slot s (bits 8s+7:8s of `chr_bank_o`) shows register s.
- R8: In mode 1, pattern slots 2k and 2k+1 are both driven by register k, for k = 0..3.
- R9: In modes 2 and 3, slots 0–3 show registers 0–3. Slots 4–5 are driven by register 4 and slots 6–7 by register 5.
- R10: For a paired slot with split set, the even slot shows the register with bit 0 cleared and the odd slot shows it with bit 0 set. With split clear, both slots show the register unchanged. Unpaired slots are never altered.
- R11: After reset, every register is 0. The outputs then read: program slots 0, 1, 0, PRG_BANKS-1; all pattern slots 0; RAM enable 0.
- R12: An output reflects a write on the second rising clock edge after the edge that samples the write. It still shows the old value after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_sel | input | 1 | Board strap: 1 swaps address bits 1 and 0 before decode |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| prg_bank_o | output | 4*PRG_W | Program slot banks, slot s at bits [s*PRG_W +: PRG_W] |
| chr_bank_o | output | 8*DATA_W | Pattern slot banks, slot s at bits [s*DATA_W +: DATA_W] |
| wram_en_o | output | 1 | Work RAM window enable |

## Verification
A write is captured into a bank register on the rising edge that sees the strobe. The routed slot value reaches the output registers on the next edge, so every result is due two rising edges after the write is applied. The bench applies each write on a falling edge, releases the strobe on the next falling edge, and samples every slot on the falling edge after that, when both edges have passed. One dedicated check samples after only the first edge, to confirm the old value is still present there.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

  typedef enum logic [2:0] {
    W_NONE   = 3'd0,
    W_PRG16  = 3'd1,
    W_PRG8   = 3'd2,
    W_CHR_LO = 3'd3,
    W_CHR_HI = 3'd4,
    W_CTRL   = 3'd5
  } wr_kind_e;

  localparam logic [15:0] ADDR_MASK  = 16'hF003;
  localparam logic [15:0] GROUP_MASK = 16'hF000;
  localparam int          PRG_SLOTS  = 4;
  localparam int          CHR_SLOTS  = 8;
  localparam int          CHR_REGS   = 8;
  localparam int          PRG16_W    = 4;
  localparam int          PRG8_W     = 5;

endpackage

// File: rtl/cbk_addr_decode.sv
module cbk_addr_decode
  import cbk_pkg::*;
(
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic        swap,
  output wr_kind_e    kind,
  output logic [1:0]  idx
);

  logic [15:0] masked;
  logic [15:0] norm;
  logic [15:0] group;

  assign masked = addr & ADDR_MASK;
  assign norm   = swap ? {masked[15:2], masked[0], masked[1]} : masked;
  assign group  = norm & GROUP_MASK;
  assign idx    = norm[1:0];

  always_comb begin
    kind = W_NONE;
    if (wr) begin
      if      (group == 16'h8000) kind = W_PRG16;
      else if (group == 16'hC000) kind = W_PRG8;
      else if (group == 16'hD000) kind = W_CHR_LO;
      else if (group == 16'hE000) kind = W_CHR_HI;
      else if (norm  == 16'hB003) kind = W_CTRL;
    end
  end

endmodule

// File: rtl/cbk_regs.sv
module cbk_regs
  import cbk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wr_kind_e                   kind,
  input  logic [1:0]                 idx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [PRG16_W-1:0]         prg16_o,
  output logic [PRG8_W-1:0]          prg8_o,
  output logic [CHR_REGS*DATA_W-1:0] chr_o,
  output logic [1:0]                 mode_o,
  output logic                       split_o,
  output logic                       wram_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prg16_o <= '0;
      prg8_o  <= '0;
      mode_o  <= '0;
      split_o <= 1'b0;
      wram_o  <= 1'b0;
    end else begin
      case (kind)
        W_PRG16: prg16_o <= wdata[PRG16_W-1:0];
        W_PRG8:  prg8_o  <= wdata[PRG8_W-1:0];
        W_CTRL: begin
          mode_o  <= wdata[1:0];
          split_o <= wdata[5];
          wram_o  <= wdata[7];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_chr
    localparam wr_kind_e HALF = (g < 4) ? W_CHR_LO : W_CHR_HI;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                     q <= '0;
      else if (kind == HALF && idx == 2'(g % 4))   q <= wdata;
    end
    assign chr_o[g*DATA_W +: DATA_W] = q;
  end

  // R3: a program 16 KB write lands in the register on the next edge
  a_r3_prg16_load: assert property (@(posedge clk) disable iff (rst)
    kind == W_PRG16 |=> prg16_o == $past(wdata[PRG16_W-1:0]));

  // R4: slot-2 bank write lands on the next edge
  a_r4_prg8_load: assert property (@(posedge clk) disable iff (rst)
    kind == W_PRG8 |=> prg8_o == $past(wdata[PRG8_W-1:0]));

  // R1: no decoded write leaves every register untouched
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    kind == W_NONE |=> $stable(prg16_o) && $stable(prg8_o) && $stable(chr_o)
                       && $stable(mode_o) && $stable(split_o) && $stable(wram_o));

endmodule

// File: rtl/cbk_chr_route.sv
module cbk_chr_route
  import cbk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [CHR_REGS*DATA_W-1:0]  regs_i,
  input  logic [1:0]                  mode_i,
  input  logic                        split_i,
  output logic [CHR_SLOTS*DATA_W-1:0] slots_o
);

  for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_slot
    localparam logic [2:0] SELF = 3'(s);
    localparam logic [2:0] HALF = 3'(s / 2);
    localparam logic [2:0] UPPR = 3'(4 + (s - 4) / 2);
    logic [2:0]        src;
    logic              paired;
    logic [DATA_W-1:0] val;

    always_comb begin
      case (mode_i)
        2'd0: begin src = SELF; paired = 1'b0; end
        2'd1: begin src = HALF; paired = 1'b1; end
        default: begin
          if (s < 4) begin src = SELF; paired = 1'b0; end
          else       begin src = UPPR; paired = 1'b1; end
        end
      endcase
      val = regs_i[src*DATA_W +: DATA_W];
      if (paired && split_i) val[0] = SELF[0];
    end

    assign slots_o[s*DATA_W +: DATA_W] = val;
  end

endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
  import cbk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PRG_W     = 8,
  parameter int PRG_BANKS = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          variant_sel,
  input  logic                          cpu_wr,
  input  logic [15:0]                   cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [PRG_SLOTS*PRG_W-1:0]    prg_bank_o,
  output logic [CHR_SLOTS*DATA_W-1:0]   chr_bank_o,
  output logic                          wram_en_o
);

  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);
  localparam logic [PRG_SLOTS*PRG_W-1:0] PRG_RST =
    {LAST_BANK, PRG_W'(0), PRG_W'(1), PRG_W'(0)};

  wr_kind_e                   kind;
  logic [1:0]                 idx;
  logic [PRG16_W-1:0]         prg16;
  logic [PRG8_W-1:0]          prg8;
  logic [CHR_REGS*DATA_W-1:0] chr_regs;
  logic [1:0]                 mode;
  logic                       split;
  logic                       wram;
  logic [CHR_SLOTS*DATA_W-1:0] chr_next;
  logic [PRG_SLOTS*PRG_W-1:0]  prg_next;

  cbk_addr_decode u_dec (
    .wr   (cpu_wr),
    .addr (cpu_addr),
    .swap (variant_sel),
    .kind (kind),
    .idx  (idx)
  );

  cbk_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .idx     (idx),
    .wdata   (cpu_wdata),
    .prg16_o (prg16),
    .prg8_o  (prg8),
    .chr_o   (chr_regs),
    .mode_o  (mode),
    .split_o (split),
    .wram_o  (wram)
  );

  cbk_chr_route #(.DATA_W(DATA_W)) u_route (
    .regs_i  (chr_regs),
    .mode_i  (mode),
    .split_i (split),
    .slots_o (chr_next)
  );

  assign prg_next = {LAST_BANK,
                     PRG_W'(prg8),
                     PRG_W'({prg16, 1'b1}),
                     PRG_W'({prg16, 1'b0})};

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank_o <= PRG_RST;
      chr_bank_o <= '0;
      wram_en_o  <= 1'b0;
    end else begin
      prg_bank_o <= prg_next;
      chr_bank_o <= chr_next;
      wram_en_o  <= wram;
    end
  end

  // R3: slot 0 even, slot 1 the next bank
  a_r3_prg_pair: assert property (@(posedge clk) disable iff (rst)
    !prg_bank_o[0] && prg_bank_o[2*PRG_W-1:PRG_W] == prg_bank_o[PRG_W-1:0] + 1'b1);

  // R4: last slot fixed
  a_r4_last_fixed: assert property (@(posedge clk) disable iff (rst)
    prg_bank_o[4*PRG_W-1:3*PRG_W] == LAST_BANK);

  // R10: slots 4 and 5 are paired in every mode but 0
  a_r10_split_parity: assert property (@(posedge clk) disable iff (rst)
    $past(split && mode != 2'd0) |->
      !chr_bank_o[4*DATA_W] && chr_bank_o[5*DATA_W]);

  // R6: RAM enable follows the stored control bit one edge later
  a_r6_wram_follow: assert property (@(posedge clk) disable iff (rst)
    wram_en_o == $past(wram));

  // R1: no strobe, no decoded write
  a_r1_idle_no_kind: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |-> kind == W_NONE);

endmodule

// File: tb/tb_cart_bank_decoder.sv
module tb_cart_bank_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        variant_sel = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [31:0] prg_bank_o;
  logic [63:0] chr_bank_o;
  logic        wram_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int        m_prg16 = 0;
  int        m_prg8  = 0;
  logic [7:0] m_chr [8];
  int        m_mode  = 0;
  bit        m_split = 0;
  bit        m_wram  = 0;

  cart_bank_decoder dut (
    .clk(clk), .rst(rst), .variant_sel(variant_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .prg_bank_o(prg_bank_o),
    .chr_bank_o(chr_bank_o), .wram_en_o(wram_en_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
    int lo;
    if (!a[15]) return;
    lo = variant_sel ? {a[0], a[1]} : a[1:0];
    case (a[15:12])
      4'h8: m_prg16 = d & 15;
      4'hC: m_prg8  = d & 31;
      4'hD: m_chr[lo] = d;
      4'hE: m_chr[4 + lo] = d;
      4'hB: if (lo == 3) begin m_mode = d[1:0]; m_split = d[5]; m_wram = d[7]; end
      default: ;
    endcase
  endfunction

  function automatic int exp_chr(input int s);
    int  src;
    bit  pr;
    logic [7:0] v;
    if (m_mode == 0)      begin src = s;     pr = 0; end
    else if (m_mode == 1) begin src = s / 2; pr = 1; end
    else if (s < 4)       begin src = s;     pr = 0; end
    else                  begin src = 4 + (s - 4) / 2; pr = 1; end
    v = m_chr[src];
    if (pr && m_split) v[0] = s[0];
    return int'(v);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit strobe = 1);
    @(negedge clk);
    cpu_wr = strobe; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    @(negedge clk);
    if (strobe) model_write(a, d);
  endtask

  task automatic check_all(input string tag);
    check({tag, " prg0"}, int'(prg_bank_o[7:0]),   2 * m_prg16);
    check({tag, " prg1"}, int'(prg_bank_o[15:8]),  2 * m_prg16 + 1);
    check({tag, " prg2"}, int'(prg_bank_o[23:16]), m_prg8);
    check("R4 prg3",      int'(prg_bank_o[31:24]), 31);
    for (int s = 0; s < 8; s++)
      check($sformatf("%s chr%0d", tag, s), int'(chr_bank_o[s*8 +: 8]), exp_chr(s));
    check("R6 wram", int'(wram_en_o), int'(m_wram));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R11");

    // R3 / R4 sweeps with mirrored addresses and junk high data bits
    for (int n = 0; n < 16; n++) begin
      wr(16'h8000 | 16'(n % 4) | 16'h0FF0, 8'(n | 8'hA0));
      check_all("R3");
    end
    for (int b = 0; b < 32; b++) begin
      wr(16'hC000 | 16'(b % 4), 8'(b | 8'hE0));
      check_all("R4");
    end

    // R12 latency
    wr(16'hC000, 8'h15);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 16'hC000; cpu_wdata = 8'h07;
    @(negedge clk);
    cpu_wr = 1'b0;
    check("R12 one edge", int'(prg_bank_o[23:16]), 8'h15);
    @(negedge clk);
    check("R12 two edges", int'(prg_bank_o[23:16]), 8'h07);
    model_write(16'hC000, 8'h07);

    // R5, R7-R10 sweep over strap, mode and split
    for (int v = 0; v < 2; v++) begin
      variant_sel = v[0];
      for (int m = 0; m < 4; m++) begin
        for (int sp = 0; sp < 2; sp++) begin
          string tag;
          wr(16'hB003, {m[0] ^ sp[0], 1'b1, sp[0], 3'b111, m[1:0]});
          for (int i = 0; i < 8; i++)
            wr((i < 4 ? 16'hD000 : 16'hE000) | 16'(i % 4),
               8'(8'h1D * i + 8'h31 * m + 8'h0B * sp + 8'h80 * v));
          if (sp == 1)      tag = "R10";
          else if (m == 0)  tag = "R7";
          else if (m == 1)  tag = "R8";
          else              tag = "R9";
          check_all(tag);
          check_all(v == 1 ? "R2" : "R5");
        end
      end
    end

    // R2 explicit swap
    variant_sel = 1'b1;
    wr(16'hB003, 8'h00);
    wr(16'hD000 | 16'h0002, 8'h11);
    wr(16'hD001, 8'h5A);
    check("R2 swap lands reg2", int'(chr_bank_o[23:16]), 8'h5A);
    check("R2 reg1 untouched", int'(chr_bank_o[15:8]), int'(m_chr[1]));
    variant_sel = 1'b0;
    wr(16'hD001, 8'hC3);
    check("R2 plain lands reg1", int'(chr_bank_o[15:8]), 8'hC3);

    // R1 ignored writes
    wr(16'hB003, 8'hA1);
    wr(16'h7003, 8'hFF); check_all("R1");
    wr(16'h9003, 8'hFF); check_all("R1");
    wr(16'hA001, 8'hFF); check_all("R1");
    wr(16'hF002, 8'hFF); check_all("R1");
    wr(16'hB001, 8'hFF); check_all("R1");
    wr(16'h8000, 8'h0F, 0); check_all("R1");
    wr(16'hDFF1, 8'h77); check_all("R1");
    wr(16'hB003, 8'h7F); check_all("R6");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule